// File: doc/BRIEF.md
# Saturating Movement Counter with Request and Acknowledge

This block sums single-cycle movement pulses into a signed count and tells a control unit when a non-zero count is waiting to be collected. An increment pulse raises the count by one and a decrement pulse lowers it by one. The count never wraps: it stops at a positive limit and at a negative limit of the same magnitude. The internal count width is a parameter. The default is two bits, which gives a range of -1 to +1. The count leaves the block as an 8-bit two's complement value, sign-extended from the internal width.

The control unit collects the count by pulsing a synchronous acknowledge for one cycle. That acknowledge discards the held value at the next rising edge. A movement pulse that arrives in the same cycle is not lost: it becomes the first step of the new count. A request flag is high whenever the registered count is non-zero. So an acknowledge lowers the request unless a new movement arrives together with it. All state is cleared by a synchronous active-low reset, which is used only for initialization. The acknowledge is a separate input and never acts as a reset.

Top module: `motion_count`

## Requirements
- R1: After any rising clock edge at which `rst_n` is low, `count_o` is 0 and `move_req_o` is low.
- R2: With `ack` low, an `up_pulse` alone (with `down_pulse` low) raises the count by one at the next edge, and a `down_pulse` alone lowers it by one, as long as the relevant limit has not been reached.
- R3: The count is confined to the range -(2^(CNT_W-1)-1) to +(2^(CNT_W-1)-1). This is -1 to +1 for CNT_W = 2. An `up_pulse` at the positive limit, or a `down_pulse` at the negative limit, leaves the count unchanged.
- R4: When `up_pulse` and `down_pulse` are high together, no step is taken. With `ack` low the count holds. With `ack` high the count becomes 0.
- R5: `ack` with neither pulse makes the count 0 and lowers `move_req_o` at the next edge.
- R6: `ack` together with `up_pulse` alone makes the next count +1, and `ack` together with `down_pulse` alone makes it -1. In both cases the old value is discarded and `move_req_o` stays high.
- R7: `move_req_o` is high exactly when the registered count is non-zero. It updates at the same edge as the count.
- R8: `count_o` is the internal count in two's complement, sign-extended to 8 bits. Bit 7 is the most significant bit, and every bit from CNT_W-1 upward equals the internal sign bit.
- R9: Over any pulse sequence, the count equals the number of increments minus the number of decrements since the last acknowledge or reset, with each step clipped at the limits of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, for initialization only |
| up_pulse | input | 1 | One-cycle increment request |
| down_pulse | input | 1 | One-cycle decrement request |
| ack | input | 1 | One-cycle synchronous acknowledge that discards the held count |
| count_o | output | 8 | Signed count, sign-extended to 8 bits |
| move_req_o | output | 1 | High while a non-zero count waits for collection |

## Verification
The hardest case to reach is an acknowledge that meets a movement pulse while the counter already sits at a limit. To reach it, the state has to be prepared first: a preceding acknowledge paired with a chosen direction forces the count to a known start value. The stimulus then applies that forcing step for each reachable start value (-1, 0 and +1) and follows it with each of the eight combinations of increment, decrement and acknowledge. The next count is computed arithmetically in the bench. A long pseudo-random pulse stream then checks the running difference against the same clipped arithmetic.

// File: rtl/motion_count_pkg.sv
// Package: motion_count_pkg
// Shared types for the movement counter. The step code is what the
// pulse decoder hands to the saturating accumulator.
package motion_count_pkg;

    // Direction of the single step requested in one cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10
    } step_e;

endpackage

// File: rtl/motion_count_step_decode.sv
// Module: motion_count_step_decode
// Turns the raw increment and decrement pulses into one step code.
// Assumes: each pulse lasts at most one cycle. When both pulses are
// high together, they cancel and the result is a hold.
module motion_count_step_decode
    import motion_count_pkg::*;
(
    input  logic  up_pulse,
    input  logic  down_pulse,
    output step_e step
);

    // Purpose: choose the step; conflicting or absent pulses give a hold.
    always_comb begin
        unique case ({up_pulse, down_pulse})
            2'b10:   step = STEP_INC;
            2'b01:   step = STEP_DEC;
            default: step = STEP_HOLD;
        endcase
    end

endmodule

// File: rtl/motion_count_sat_acc.sv
// Module: motion_count_sat_acc
// Signed saturating accumulator with a synchronous acknowledge clear.
// When the acknowledge is high, the held value is replaced by zero before
// the step is applied, so a step in the same cycle survives. The request
// register is loaded from the same next value, which keeps it in step
// with the count. Limits are symmetric, +/-(2^(CNT_W-1)-1).
// Assumes: CNT_W >= 2. Reset is synchronous and active low.
module motion_count_sat_acc
    import motion_count_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ack,
    input  step_e                   step,
    output logic signed [CNT_W-1:0] cnt_q,
    output logic                    req_q
);

    localparam logic signed [CNT_W-1:0] POS_LIM = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] NEG_LIM = -POS_LIM;
    localparam logic signed [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    logic signed [CNT_W-1:0] base;
    logic signed [CNT_W-1:0] cnt_nxt;

    // Purpose: start from zero when acknowledged, otherwise from the held count.
    always_comb begin
        base = ack ? '0 : cnt_q;
    end

    // Purpose: apply one step to the base, clipping at the symmetric limits.
    always_comb begin
        cnt_nxt = base;
        unique case (step)
            STEP_INC: if (base != POS_LIM) cnt_nxt = base + ONE;
            STEP_DEC: if (base != NEG_LIM) cnt_nxt = base - ONE;
            default:  cnt_nxt = base;
        endcase
    end

    // Purpose: register the count and the pending-request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            req_q <= (cnt_nxt != '0);
        end
    end

endmodule

// File: rtl/motion_count_sext.sv
// Module: motion_count_sext
// Sign-extends a narrow two's complement value to a wider bus.
// Assumes: 1 <= IN_W <= OUT_W. Purely combinational.
module motion_count_sext #(
    parameter int IN_W  = 2,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);

    // Purpose: copy the low bits and replicate the sign bit upward.
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        if (i < IN_W) begin : g_copy
            assign val_o[i] = val_i[i];
        end else begin : g_sign
            assign val_o[i] = val_i[IN_W-1];
        end
    end

endmodule

// File: rtl/motion_count.sv
// Module: motion_count (top)
// Movement counter: decodes the direction pulses, accumulates them with
// saturation and a synchronous acknowledge clear, and presents the
// count sign-extended to OUT_W bits together with a pending request.
// Assumes: up_pulse, down_pulse and ack are synchronous to clk and last
// one cycle each. rst_n is synchronous, active low, for initialization.
module motion_count
    import motion_count_pkg::*;
#(
    parameter int CNT_W = 2,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_pulse,
    input  logic             down_pulse,
    input  logic             ack,
    output logic [OUT_W-1:0] count_o,
    output logic             move_req_o
);

    step_e                   step;
    logic signed [CNT_W-1:0] cnt_q;

    motion_count_step_decode u_dec (
        .up_pulse   (up_pulse),
        .down_pulse (down_pulse),
        .step       (step)
    );

    motion_count_sat_acc #(
        .CNT_W (CNT_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ack),
        .step  (step),
        .cnt_q (cnt_q),
        .req_q (move_req_o)
    );

    motion_count_sext #(
        .IN_W  (CNT_W),
        .OUT_W (OUT_W)
    ) u_sext (
        .val_i (cnt_q),
        .val_o (count_o)
    );

endmodule

// File: rtl/motion_count_chk.sv
// Module: motion_count_chk
// Port-level properties of motion_count, attached through bind.
module motion_count_chk #(
    parameter int CNT_W = 2,
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_pulse,
    input logic             down_pulse,
    input logic             ack,
    input logic [OUT_W-1:0] count_o,
    input logic             move_req_o
);

    localparam logic signed [OUT_W-1:0] POS = OUT_W'((1 << (CNT_W-1)) - 1);
    localparam logic signed [OUT_W-1:0] NEG = -POS;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && !move_req_o));

    assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && !down_pulse && !ack && $signed(count_o) < POS)
        |=> $signed(count_o) == $signed($past(count_o)) + 1);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(count_o) <= POS && $signed(count_o) >= NEG);

    assert_limit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && !down_pulse && !ack && $signed(count_o) == POS)
        |=> $signed(count_o) == POS);

    assert_both_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && down_pulse && !ack) |=> $stable(count_o));

    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !up_pulse && !down_pulse) |=> (count_o == '0 && !move_req_o));

    assert_ack_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && up_pulse && !down_pulse) |=> ($signed(count_o) == 1 && move_req_o));

    assert_ack_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && down_pulse && !up_pulse) |=> ($signed(count_o) == -1 && move_req_o));

    assert_req_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        move_req_o == (count_o != '0));

    assert_sign_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count_o[OUT_W-1:CNT_W-1] == '0 || count_o[OUT_W-1:CNT_W-1] == '1);

endmodule

bind motion_count motion_count_chk #(
    .CNT_W (CNT_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_pulse   (up_pulse),
    .down_pulse (down_pulse),
    .ack        (ack),
    .count_o    (count_o),
    .move_req_o (move_req_o)
);

// File: tb/motion_count_tb.sv
module motion_count_tb;

    localparam int CNT_W = 2;
    localparam int OUT_W = 8;
    localparam int LIM   = (1 << (CNT_W-1)) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             up_pulse = 1'b0;
    logic             down_pulse = 1'b0;
    logic             ack = 1'b0;
    logic [OUT_W-1:0] count_o;
    logic             move_req_o;

    int  n_vec  = 0;
    int  n_fail = 0;
    int  exp_c  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    motion_count #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_pulse   (up_pulse),
        .down_pulse (down_pulse),
        .ack        (ack),
        .count_o    (count_o),
        .move_req_o (move_req_o)
    );

    // Clipped arithmetic model of one cycle.
    function automatic int model(int c, bit u, bit d, bit a);
        int b = a ? 0 : c;
        if (u && !d)      b = (b < LIM)  ? b + 1 : b;
        else if (d && !u) b = (b > -LIM) ? b - 1 : b;
        return b;
    endfunction

    task automatic check(string tag);
        logic [OUT_W-1:0] e = OUT_W'(exp_c);
        n_vec++;
        if (count_o !== e) begin
            n_fail++;
            $display("FAIL %s count actual=%0h expected=%0h", tag, count_o, e);
        end
        n_vec++;
        if (move_req_o !== (exp_c != 0)) begin
            n_fail++;
            $display("FAIL R7 req actual=%0b expected=%0b", move_req_o, exp_c != 0);
        end
    endtask

    task automatic apply(bit u, bit d, bit a, string tag);
        @(negedge clk);
        up_pulse = u; down_pulse = d; ack = a;
        exp_c = model(exp_c, u, d, a);
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; up_pulse = 0; down_pulse = 0; ack = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_c = 0;
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        #1;
        exp_c = 0;
        check("R1");  // reset state
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep: each start value -1/0/+1 crossed with all 8 input combinations.
        for (int s = -1; s <= 1; s++) begin
            for (int c = 0; c < 8; c++) begin
                bit u = c[0], d = c[1], a = c[2];
                string tag;
                apply(s > 0, s < 0, 1'b1, (s == 0) ? "R5" : "R6");  // force start
                if (a)                       tag = (u ^ d) ? "R6" : (u ? "R4" : "R5");
                else if (u && d)             tag = "R4";
                else if ((u && s == LIM) || (d && s == -LIM)) tag = "R3";
                else                         tag = "R2";
                apply(u, d, a, tag);
                apply(u, d, 1'b0, "R8");  // repeat without ack: reaches limits
            end
        end

        // Pseudo-random run: running clipped difference since last ack.
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr[0], lfsr[1], lfsr[4:2] == 3'b000, "R9");
        end

        // Reset in the middle of activity.
        apply(1'b1, 1'b0, 1'b1, "R6");
        do_reset();
        #2; check("R1");
        apply(1'b0, 1'b1, 1'b0, "R2");
        do_reset();
        #2; check("R1");

        @(negedge clk);
        up_pulse = 0; down_pulse = 0; ack = 0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule